// File: doc/BRIEF.md
# Address Space Decoder with Remap

This block sorts every processor access on a 32-bit address bus into one of three regions: on-chip memory at the very bottom of the 4 GB space, on-chip peripherals at the very top, and the external bus for everything in between. The bottom and top regions are each 4 MB wide. The block also holds a one-shot remap flag. Until the flag is set, the bottom region is routed to the external bus so that the processor boots from an external device. Once a remap command has been seen, the bottom region selects the internal 256 KB SRAM, which makes the exception vectors near address zero writable.

For SRAM accesses the block turns the access size and the two low address bits into byte-lane enables for a 32-bit little-endian data path. It also gives the SRAM word index, a write enable, and read data shifted down to bit 0. Accesses that do not fit their own size boundary are stopped with an abort flag and select nothing.

The selects, the lane enables and the aligned read data are combinational from the access inputs. Only the remap flag is a register, updated on the rising clock edge with a synchronous active-high reset.

Top module: `addr_map_remap`

## Requirements
- R1: A valid, aligned access whose address bits [31:22] are all ones asserts `sel_per` only.
- R2: A valid, aligned access whose address bits [31:22] are neither all zeros nor all ones asserts `sel_ext` only.
- R3: While `remapped` is 0, a valid, aligned access with address bits [31:22] all zero asserts `sel_ext` only, and `lane_en` is 0.
- R4: While `remapped` is 1, a valid, aligned access with address bits [31:22] all zero asserts `sel_int` only.
- R5: `remap_cmd` high at a rising edge (reset low) sets `remapped` from the next cycle on. Once set, the flag stays set, and a further command has no effect.
- R6: The size codes are 0 = byte, 1 = half-word, 2 = word. On an SRAM select, a byte gives `lane_en` = 1 << addr[1:0], a half-word gives 4'b0011 (addr[1]=0) or 4'b1100 (addr[1]=1), and a word gives 4'b1111. Without an SRAM select, `lane_en` is 0.
- R7: `abort` is 1 for a valid access in any of these cases: a half-word with addr[0]=1, a word with addr[1:0]≠0, or size code 3. While `abort` is 1, all three selects, `lane_en` and `sram_we` are 0.
- R8: `sram_word` equals addr[17:2], so SRAM addresses above 256 KB alias and the bits above 17 are ignored.
- R9: `rdata_out` takes `rdata_in` in little-endian order. A byte gives (rdata_in >> 8·addr[1:0]) & 0xFF, a half-word gives (rdata_in >> 16·addr[1]) & 0xFFFF, a word gives rdata_in unchanged, and size code 3 gives 0.
- R10: With `acc_valid` low, all selects, `lane_en`, `sram_we` and `abort` are 0.
- R11: A rising edge with `rst` high clears `remapped` to 0 from the next cycle, whatever `remap_cmd` is.
- R12: `sram_we` is 1 exactly when `sel_int` is 1 and `acc_write` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| remap_cmd | input | 1 | Remap request, sampled on the rising edge |
| rdata_in | input | 32 | Raw 32-bit word read from SRAM |
| sel_int | output | 1 | Internal SRAM selected |
| sel_ext | output | 1 | External bus selected |
| sel_per | output | 1 | Peripheral region selected |
| lane_en | output | 4 | Byte-lane enables, bit i = byte i |
| sram_word | output | 16 | SRAM word index |
| sram_we | output | 1 | SRAM write enable |
| abort | output | 1 | Misaligned or reserved-size access |
| remapped | output | 1 | Remap flag |
| rdata_out | output | 32 | Read data shifted to bit 0, zero-extended |

## Verification
The hardest state to reach is the transition of the bottom region from boot routing to SRAM. Reaching it needs a remap command, then proof that the change holds across a repeated command, and then that only reset undoes it. The stimulus runs the same low addresses before the command, after it and after a mid-run reset. It also issues the second command while an SRAM access is under way in the same cycle. The scoreboard model tracks the flag by cycle, so each item's expected routing follows the edge at which the flag changes.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

    localparam int unsigned LANES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_INT  = 2'd1,
        RG_EXT  = 2'd2,
        RG_PER  = 2'd3
    } region_e;

    // An access must sit on its own size boundary.
    function automatic logic is_misaligned(acc_size_e sz, logic [1:0] low);
        case (sz)
            SZ_BYTE: is_misaligned = 1'b0;
            SZ_HALF: is_misaligned = low[0];
            SZ_WORD: is_misaligned = |low;
            default: is_misaligned = 1'b1;
        endcase
    endfunction

    // Decides whether byte lane ln is part of an access.
    function automatic logic lane_hit(acc_size_e sz, logic [1:0] low, int unsigned ln);
        logic [1:0] l;
        l = ln[1:0];
        case (sz)
            SZ_BYTE: lane_hit = (l == low);
            SZ_HALF: lane_hit = (l[1] == low[1]);
            SZ_WORD: lane_hit = 1'b1;
            default: lane_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    output logic remapped
);
    always_ff @(posedge clk) begin
        if (rst)
            remapped <= 1'b0;
        else if (cmd)
            remapped <= 1'b1;
    end

    // R5
    remap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        remapped |=> remapped);

    // R11
    remap_clear_chk: assert property (@(posedge clk)
        rst |=> !remapped);
endmodule

// File: rtl/addr_region_dec.sv
module addr_region_dec
    import addr_map_pkg::*;
#(
    parameter int unsigned TOP_W = 10
) (
    input  logic             enable,
    input  logic [TOP_W-1:0] top_bits,
    input  logic             remapped,
    output region_e          region
);
    localparam logic [TOP_W-1:0] TOP_LOW  = '0;
    localparam logic [TOP_W-1:0] TOP_HIGH = '1;

    always_comb begin
        if (!enable)
            region = RG_NONE;
        else if (top_bits == TOP_HIGH)
            region = RG_PER;
        else if (top_bits == TOP_LOW)
            region = remapped ? RG_INT : RG_EXT;
        else
            region = RG_EXT;
    end
endmodule

// File: rtl/lane_gen.sv
module lane_gen
    import addr_map_pkg::*;
(
    input  acc_size_e        size,
    input  logic [1:0]       low,
    output logic [LANES-1:0] lanes,
    output logic             misalign
);
    assign misalign = is_misaligned(size, low);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = lane_hit(size, low, g);
    end
endmodule

// File: rtl/rdata_align.sv
module rdata_align
    import addr_map_pkg::*;
(
    input  acc_size_e        size,
    input  logic [1:0]       low,
    input  logic [8*LANES-1:0] raw,
    output logic [8*LANES-1:0] aligned
);
    logic [7:0] bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign bytes[g] = raw[8*g +: 8];
    end

    always_comb begin
        aligned = '0;
        case (size)
            SZ_BYTE: aligned[7:0]  = bytes[low];
            SZ_HALF: aligned[15:0] = low[1] ? raw[31:16] : raw[15:0];
            SZ_WORD: aligned       = raw;
            default: aligned       = '0;
        endcase
    end
endmodule

// File: rtl/addr_map_remap.sv
module addr_map_remap
    import addr_map_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TOP_W   = 10,
    parameter int unsigned SRAM_AW = 18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [1:0]            acc_size,
    input  logic                  remap_cmd,
    input  logic [31:0]           rdata_in,
    output logic                  sel_int,
    output logic                  sel_ext,
    output logic                  sel_per,
    output logic [3:0]            lane_en,
    output logic [SRAM_AW-3:0]    sram_word,
    output logic                  sram_we,
    output logic                  abort,
    output logic                  remapped,
    output logic [31:0]           rdata_out
);
    localparam int unsigned MID_LO = SRAM_AW;
    localparam int unsigned MID_HI = ADDR_W - TOP_W - 1;

    acc_size_e        size_e;
    logic             misalign;
    logic [LANES-1:0] raw_lanes;
    region_e          region;
    logic             unused_mid;

    assign size_e     = acc_size_e'(acc_size);
    assign unused_mid = ^acc_addr[MID_HI:MID_LO];

    remap_ctrl u_remap (
        .clk      (clk),
        .rst      (rst),
        .cmd      (remap_cmd),
        .remapped (remapped)
    );

    lane_gen u_lanes (
        .size     (size_e),
        .low      (acc_addr[1:0]),
        .lanes    (raw_lanes),
        .misalign (misalign)
    );

    assign abort = acc_valid & misalign;

    addr_region_dec #(.TOP_W(TOP_W)) u_dec (
        .enable   (acc_valid & ~misalign),
        .top_bits (acc_addr[ADDR_W-1 -: TOP_W]),
        .remapped (remapped),
        .region   (region)
    );

    assign sel_int   = (region == RG_INT);
    assign sel_ext   = (region == RG_EXT);
    assign sel_per   = (region == RG_PER);
    assign lane_en   = sel_int ? raw_lanes : '0;
    assign sram_we   = sel_int & acc_write;
    assign sram_word = acc_addr[SRAM_AW-1:2];

    rdata_align u_align (
        .size    (size_e),
        .low     (acc_addr[1:0]),
        .raw     (rdata_in),
        .aligned (rdata_out)
    );

    // R7
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> (lane_en == '0 && !sel_int && !sel_ext && !sel_per && !sram_we));

    // R6
    lanes_need_int_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_en != '0) |-> sel_int);

    // R1
    periph_top_chk: assert property (@(posedge clk) disable iff (rst)
        sel_per |-> (&acc_addr[ADDR_W-1 -: TOP_W]));

    // R4
    int_needs_remap_chk: assert property (@(posedge clk) disable iff (rst)
        sel_int |-> (remapped && acc_addr[ADDR_W-1 -: TOP_W] == '0));

    // R5
    remap_set_chk: assert property (@(posedge clk) disable iff (rst)
        remap_cmd |=> remapped);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !(sel_int || sel_ext || sel_per || abort));
endmodule

// File: tb/test_addr_map_remap.sv
module test_addr_map_remap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        remap_cmd = 1'b0;
    logic [31:0] rdata_in = '0;
    logic        sel_int, sel_ext, sel_per, sram_we, abort, remapped;
    logic [3:0]  lane_en;
    logic [15:0] sram_word;
    logic [31:0] rdata_out;

    always #2 clk = ~clk;

    addr_map_remap i_addr_map_remap (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .remap_cmd(remap_cmd),
        .rdata_in(rdata_in), .sel_int(sel_int), .sel_ext(sel_ext),
        .sel_per(sel_per), .lane_en(lane_en), .sram_word(sram_word),
        .sram_we(sram_we), .abort(abort), .remapped(remapped),
        .rdata_out(rdata_out)
    );

    typedef struct {
        logic [2:0]  sel;
        logic [3:0]  lanes;
        logic [15:0] word;
        logic        we;
        logic        abt;
        logic        rem;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    logic model_rem = 1'b0;
    bit   finished = 1'b0;

    task automatic drive(input logic r, input logic v, input logic w,
                         input logic [31:0] a, input logic [1:0] s,
                         input logic cmd, input logic [31:0] rd, input string tag);
        exp_t e;
        logic [9:0] top;
        logic mis, ok;
        @(negedge clk);
        rst = r; acc_valid = v; acc_write = w; acc_addr = a;
        acc_size = s; remap_cmd = cmd; rdata_in = rd;
        top = a[31:22];
        mis = (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 2'b00) || s == 2'd3;
        ok  = v && !mis;
        e.abt = v && mis;
        e.sel[2] = ok && top == 10'h000 && model_rem;
        e.sel[1] = ok && ((top == 10'h000 && !model_rem) || (top != 10'h000 && top != 10'h3FF));
        e.sel[0] = ok && top == 10'h3FF;
        e.lanes = 4'b0000;
        if (e.sel[2]) begin
            case (s)
                2'd0: e.lanes = 4'b0001 << a[1:0];
                2'd1: e.lanes = a[1] ? 4'b1100 : 4'b0011;
                default: e.lanes = 4'b1111;
            endcase
        end
        e.word = a[17:2];
        e.we = e.sel[2] && w;
        case (s)
            2'd0: e.rd = (rd >> (8 * a[1:0])) & 32'hFF;
            2'd1: e.rd = (rd >> (16 * a[1])) & 32'hFFFF;
            2'd2: e.rd = rd;
            default: e.rd = 32'h0;
        endcase
        e.rem = model_rem;
        e.tag = tag;
        q.push_back(e);
        if (r) model_rem = 1'b0;
        else if (cmd) model_rem = 1'b1;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [2:0] got_sel;
                e = q.pop_front();
                got_sel = {sel_int, sel_ext, sel_per};
                total++;
                if (got_sel !== e.sel || lane_en !== e.lanes || sram_word !== e.word ||
                    sram_we !== e.we || abort !== e.abt || remapped !== e.rem ||
                    rdata_out !== e.rd) begin
                    bad++;
                    $display("FAIL %s: got sel=%b lanes=%b word=%h we=%b abort=%b rem=%b rd=%h exp sel=%b lanes=%b word=%h we=%b abort=%b rem=%b rd=%h",
                        e.tag, got_sel, lane_en, sram_word, sram_we, abort, remapped, rdata_out,
                        e.sel, e.lanes, e.word, e.we, e.abt, e.rem, e.rd);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        drive(1, 0, 0, 32'h0, 2'd2, 0, 32'h0, "R11 reset");
        drive(1, 0, 0, 32'h0, 2'd2, 1, 32'h0, "R11 reset with cmd");
        // R10 idle
        drive(0, 0, 1, 32'h0000_0010, 2'd2, 0, 32'h0, "R10 idle");
        // R3 boot routing
        drive(0, 1, 0, 32'h0000_0000, 2'd2, 0, 32'h1234_5678, "R3 boot word");
        drive(0, 1, 1, 32'h0000_0021, 2'd0, 0, 32'h0, "R3 boot byte write");
        // R2 external
        drive(0, 1, 0, 32'h0040_0000, 2'd2, 0, 32'h0, "R2 ext low edge");
        drive(0, 1, 1, 32'hFFBF_FFFC, 2'd2, 0, 32'h0, "R2 ext high edge");
        drive(0, 1, 0, 32'h8000_0002, 2'd1, 0, 32'h0, "R2 ext half");
        // R1 peripherals
        drive(0, 1, 0, 32'hFFC0_0000, 2'd2, 0, 32'h0, "R1 per low edge");
        drive(0, 1, 1, 32'hFFFF_FFFF, 2'd0, 0, 32'h0, "R1 per top byte");
        // R7 aborts
        drive(0, 1, 0, 32'h0040_0001, 2'd1, 0, 32'h0, "R7 odd half");
        drive(0, 1, 1, 32'hFFC0_0002, 2'd2, 0, 32'h0, "R7 word off by 2");
        drive(0, 1, 0, 32'h0000_0000, 2'd3, 0, 32'hFFFF_FFFF, "R7 reserved size");
        // R5 remap
        drive(0, 0, 0, 32'h0, 2'd2, 1, 32'h0, "R5 remap cmd");
        drive(0, 0, 0, 32'h0, 2'd2, 0, 32'h0, "R5 remap set");
        // R4 / R12 SRAM
        drive(0, 1, 1, 32'h0000_0010, 2'd2, 0, 32'h0, "R4 R12 word write");
        drive(0, 1, 0, 32'h0000_0010, 2'd2, 0, 32'hCAFE_F00D, "R12 word read");
        // R6 / R9 bytes and halves
        for (int i = 0; i < 4; i++)
            drive(0, 1, 0, 32'h0000_0020 + i, 2'd0, 0, 32'hA1B2_C3D4, "R6 R9 byte lane");
        drive(0, 1, 0, 32'h0000_0020, 2'd1, 0, 32'hA1B2_C3D4, "R6 R9 low half");
        drive(0, 1, 1, 32'h0000_0022, 2'd1, 0, 32'hA1B2_C3D4, "R6 R9 high half");
        drive(0, 1, 0, 32'h0000_0023, 2'd2, 0, 32'h0, "R7 after remap");
        // R8 aliasing
        drive(0, 1, 0, 32'h0004_0008, 2'd2, 0, 32'h0, "R8 alias 256K");
        drive(0, 1, 0, 32'h003F_FFFC, 2'd2, 0, 32'h0, "R8 alias top");
        // R5 second command ignored
        drive(0, 1, 1, 32'h0000_0004, 2'd2, 1, 32'h0, "R5 second cmd");
        drive(0, 1, 0, 32'h0000_0004, 2'd2, 0, 32'h0, "R5 still remapped");
        // R11 reset clears, R3 again
        drive(1, 0, 0, 32'h0, 2'd2, 0, 32'h0, "R11 mid reset");
        drive(0, 1, 0, 32'h0000_0004, 2'd2, 0, 32'h0, "R11 R3 after reset");
        drive(0, 0, 0, 32'h0, 2'd2, 0, 32'h0, "R10 tail idle");
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule